// File: doc/BRIEF.md
# Paged Program Counter Sequencer

This block holds the program counter of a small microcontroller core and chooses its next value every clock. In the usual case it moves to the next address. It can also jump, call a subroutine, return, return with a literal for the working register, return from an interrupt, or skip the next instruction.

A jump or call builds its target from two parts. The low bits come from an 11-bit immediate in the instruction. The two top bits come from a page latch register that the core writes on its own. Return addresses are kept in a small circular hardware stack.

The core fetches one instruction ahead. Whenever the flow of control changes, the instruction already fetched is wrong. The block cancels it by raising a flush strobe for one cycle, and while that strobe is high every control input is ignored. A skip works the same way: it does not branch, it only cancels the instruction that follows.

Top module: `pc_sequencer`

## Requirements
- R1: While reset is active and before any operation, `pc` is 0, and `flush`, `gie` and `w_wr` are 0.
- R2: An executed `op` of 0 (sequential) or 7 (reserved) advances `pc` by one on the next edge. The address 8191 wraps to 0.
- R3: An executed `op` of 1 (jump) loads `pc` on the next edge with `{page[4:3], imm[10:0]}`. Page bits 2:0 have no effect.
- R4: An executed `op` of 2 (call) pushes the current `pc` onto the stack and loads the target that R3 defines. An executed `op` of 3 (return) loads `pc` with the most recently pushed value and pops it.
- R5: After every executed jump, call, return, return-with-literal or return-from-interrupt, `flush` is 1 for exactly one cycle. During that cycle `op` is ignored and `pc` advances by one.
- R6: An executed `op` of 4 (return-with-literal) drives `w_wr`=1 and `w_data`=`lit` in the same cycle, and it pops the stack into `pc` as R4 describes. A flushed `op` of 4 leaves `w_wr` at 0.
- R7: An executed `op` of 5 (return-from-interrupt) pops the stack into `pc` and sets `gie` to 1 on the next edge. A pulse on `gie_clr` clears `gie`.
- R8: An executed `op` of 6 (skip) with `skip_hit`=1 raises `flush` on the next edge, and `pc` advances by one. With `skip_hit`=0 it acts like a sequential step and `flush` stays 0.
- R9: The stack returns up to 8 nested call addresses in last-in, first-out order.
- R10: A ninth push without a pop overwrites the oldest entry. After the 8 surviving entries have been popped, a further pop returns the ninth pushed value again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| op | input | 3 | Decoded control-flow operation of the instruction in execute |
| imm | input | 11 | Branch target immediate |
| page | input | 5 | Page latch register value; bits 4:3 are used |
| skip_hit | input | 1 | Skip condition met (bit test matched, or the increment/decrement result is zero) |
| lit | input | 8 | Literal for return-with-literal |
| gie_clr | input | 1 | Clears the global interrupt enable |
| pc | output | 13 | Program counter, which is the fetch address |
| flush | output | 1 | Current instruction is cancelled and runs as a no-operation |
| gie | output | 1 | Global interrupt enable |
| w_wr | output | 1 | Write strobe for the working register |
| w_data | output | 8 | Literal to be written to the working register |

## Verification
The bench sends a control-flow strobe during a flush cycle and checks that `pc` only advances and that `w_wr` stays low. A design that failed to gate operations this way would branch or write the working register from a cancelled instruction.

It checks the wrap from 8191 to 0, and it sets the low page bits to 1 to catch a target built from the wrong bits of the page latch.

It nests calls eight deep and then nine deep. An off-by-one stack pointer, or a stack that saturates instead of wrapping, would return addresses in the wrong order or fail to give back the ninth value on the extra pop.

A skip with the condition false must leave `flush` low. A design that skipped unconditionally would lose an instruction there.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;
  typedef enum logic [2:0] {
    OP_SEQ    = 3'd0,
    OP_JUMP   = 3'd1,
    OP_CALL   = 3'd2,
    OP_RET    = 3'd3,
    OP_RETLW  = 3'd4,
    OP_RETFIE = 3'd5,
    OP_SKIP   = 3'd6,
    OP_RSVD   = 3'd7
  } flow_op_e;
endpackage

// File: rtl/pc_seq_stack.sv
module pc_seq_stack #(
  parameter int DEPTH = 8,
  parameter int W     = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] top
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic [PTR_W-1:0] rd_idx;
  logic [W-1:0]     slot [DEPTH];

  // pointer next state: wraps naturally, depth must be a power of two
  always_comb begin
    ptr_d = ptr_q;
    if (push)     ptr_d = ptr_q + 1'b1;
    else if (pop) ptr_d = ptr_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  // storage slots, no reset, each with its own write enable
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic wr_en;
    assign wr_en = push && (ptr_q == PTR_W'(i));
    always_ff @(posedge clk) begin
      if (wr_en) slot[i] <= din;
    end
  end

  assign rd_idx = ptr_q - 1'b1;
  assign top    = slot[rd_idx];
endmodule

// File: rtl/pc_seq_nextpc.sv
module pc_seq_nextpc
  import pc_seq_pkg::*;
#(
  parameter int PC_W     = 13,
  parameter int IMM_W    = 11,
  parameter int PAGE_W   = 5,
  parameter int PAGE_LSB = 3
) (
  input  logic [2:0]        op,
  input  logic              valid,
  input  logic              skip_hit,
  input  logic [PC_W-1:0]   pc,
  input  logic [IMM_W-1:0]  imm,
  input  logic [PAGE_W-1:0] page,
  input  logic [PC_W-1:0]   stk_top,
  output logic [PC_W-1:0]   pc_nxt,
  output logic              push,
  output logic              pop,
  output logic              redirect,
  output logic              skip_take,
  output logic              gie_set,
  output logic              w_take
);
  localparam int HI_W = PC_W - IMM_W;

  flow_op_e         kind;
  logic [PC_W-1:0]  target;

  assign kind   = flow_op_e'(op);
  assign target = {page[PAGE_LSB +: HI_W], imm};

  always_comb begin
    pc_nxt    = pc + 1'b1;
    push      = 1'b0;
    pop       = 1'b0;
    redirect  = 1'b0;
    skip_take = 1'b0;
    gie_set   = 1'b0;
    w_take    = 1'b0;
    if (valid) begin
      unique case (kind)
        OP_JUMP: begin
          pc_nxt   = target;
          redirect = 1'b1;
        end
        OP_CALL: begin
          pc_nxt   = target;
          push     = 1'b1;
          redirect = 1'b1;
        end
        OP_RET, OP_RETLW, OP_RETFIE: begin
          pc_nxt   = stk_top;
          pop      = 1'b1;
          redirect = 1'b1;
          gie_set  = (kind == OP_RETFIE);
          w_take   = (kind == OP_RETLW);
        end
        OP_SKIP: skip_take = skip_hit;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pc_seq_pkg::*;
#(
  parameter int PC_W      = 13,
  parameter int IMM_W     = 11,
  parameter int PAGE_W    = 5,
  parameter int PAGE_LSB  = 3,
  parameter int LIT_W     = 8,
  parameter int STK_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op,
  input  logic [IMM_W-1:0]  imm,
  input  logic [PAGE_W-1:0] page,
  input  logic              skip_hit,
  input  logic [LIT_W-1:0]  lit,
  input  logic              gie_clr,
  output logic [PC_W-1:0]   pc,
  output logic              flush,
  output logic              gie,
  output logic              w_wr,
  output logic [LIT_W-1:0]  w_data
);
  logic [1:0]      rst_sync_q;
  logic            rst_int_n;
  logic [PC_W-1:0] pc_q, pc_d;
  logic            flush_q, flush_d;
  logic            gie_q, gie_d;
  logic [PC_W-1:0] stk_top;
  logic            push, pop, redirect, skip_take, gie_set, w_take;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pc_seq_nextpc #(
    .PC_W(PC_W), .IMM_W(IMM_W), .PAGE_W(PAGE_W), .PAGE_LSB(PAGE_LSB)
  ) u_nextpc (
    .op(op), .valid(!flush_q), .skip_hit(skip_hit), .pc(pc_q),
    .imm(imm), .page(page), .stk_top(stk_top), .pc_nxt(pc_d),
    .push(push), .pop(pop), .redirect(redirect), .skip_take(skip_take),
    .gie_set(gie_set), .w_take(w_take)
  );

  pc_seq_stack #(.DEPTH(STK_DEPTH), .W(PC_W)) u_stack (
    .clk(clk), .rst_n(rst_int_n), .push(push), .pop(pop),
    .din(pc_q), .top(stk_top)
  );

  always_comb begin
    flush_d = redirect | skip_take;
    gie_d   = gie_q;
    if (gie_set)      gie_d = 1'b1;
    else if (gie_clr) gie_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pc_q    <= '0;
      flush_q <= 1'b0;
      gie_q   <= 1'b0;
    end else begin
      pc_q    <= pc_d;
      flush_q <= flush_d;
      gie_q   <= gie_d;
    end
  end

  assign pc     = pc_q;
  assign flush  = flush_q;
  assign gie    = gie_q;
  assign w_wr   = w_take;
  assign w_data = lit;
endmodule

// File: rtl/pc_seq_chk.sv
module pc_seq_chk #(
  parameter int PC_W     = 13,
  parameter int IMM_W    = 11,
  parameter int PAGE_W   = 5,
  parameter int PAGE_LSB = 3
) (
  input logic              clk,
  input logic              rst_int_n,
  input logic [2:0]        op,
  input logic [IMM_W-1:0]  imm,
  input logic [PAGE_W-1:0] page,
  input logic              skip_hit,
  input logic [PC_W-1:0]   pc,
  input logic              flush,
  input logic              gie,
  input logic              w_wr
);
  localparam int HI_W = PC_W - IMM_W;

  AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!flush && (op == 3'd0 || op == 3'd7)) |=> pc == PC_W'($past(pc) + 1'b1)); // R2
  AST_JUMP_DEST: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!flush && op == 3'd1) |=> pc == {$past(page[PAGE_LSB +: HI_W]), $past(imm)}); // R3
  AST_BRANCH_FLUSH: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!flush && op >= 3'd1 && op <= 3'd5) |=> flush); // R5
  AST_FLUSH_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_int_n)
    flush |=> (!flush && pc == PC_W'($past(pc) + 1'b1))); // R5
  AST_FLUSH_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_int_n)
    flush |-> !w_wr); // R6
  AST_RETFIE_GIE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!flush && op == 3'd5) |=> gie); // R7
  AST_SKIP_HIT: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!flush && op == 3'd6 && skip_hit) |=> flush); // R8
  AST_SKIP_MISS: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!flush && op == 3'd6 && !skip_hit) |=> (!flush && pc == PC_W'($past(pc) + 1'b1))); // R8
endmodule

bind pc_sequencer pc_seq_chk #(
  .PC_W(PC_W), .IMM_W(IMM_W), .PAGE_W(PAGE_W), .PAGE_LSB(PAGE_LSB)
) u_chk (
  .clk(clk), .rst_int_n(rst_int_n), .op(op), .imm(imm), .page(page),
  .skip_hit(skip_hit), .pc(pc), .flush(flush), .gie(gie), .w_wr(w_wr)
);

// File: tb/tb_pc_sequencer.sv
`timescale 1ns/1ps
module tb_pc_sequencer;
  localparam logic [2:0] SEQ = 3'd0, JMP = 3'd1, CAL = 3'd2, RET = 3'd3,
                         RLW = 3'd4, RFI = 3'd5, SKP = 3'd6, RSV = 3'd7;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  op;
  logic [10:0] imm;
  logic [4:0]  page;
  logic        skip_hit;
  logic [7:0]  lit;
  logic        gie_clr;
  logic [12:0] pc;
  logic        flush, gie, w_wr;
  logic [7:0]  w_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  pc_sequencer dut (
    .clk(clk), .rst_n(rst_n), .op(op), .imm(imm), .page(page),
    .skip_hit(skip_hit), .lit(lit), .gie_clr(gie_clr), .pc(pc),
    .flush(flush), .gie(gie), .w_wr(w_wr), .w_data(w_data)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // drive one operation, take one edge, land at the falling edge
  task automatic step(input logic [2:0] o, input logic [10:0] i = '0,
                      input logic [4:0] p = '0, input logic h = 1'b0);
    op = o; imm = i; page = p; skip_hit = h;
    @(posedge clk);
    @(negedge clk);
    op = SEQ; skip_hit = 1'b0;
  endtask

  task automatic do_call(input logic [10:0] t, output logic [12:0] ret_addr);
    ret_addr = pc;
    step(CAL, t);
    step(SEQ);
  endtask

  task automatic do_ret(output logic [12:0] got);
    step(RET);
    got = pc;
    step(SEQ);
  endtask

  task automatic t_reset();
    chk("R1 pc", 32'(pc), 0);
    chk("R1 flush", 32'(flush), 0);
    chk("R1 gie", 32'(gie), 0);
    chk("R1 w_wr", 32'(w_wr), 0);
  endtask

  task automatic t_seq();
    logic [12:0] p = pc;
    step(SEQ); step(RSV); step(SEQ);
    chk("R2 advance", 32'(pc), 32'(13'(p + 3)));
    chk("R2 no flush", 32'(flush), 0);
  endtask

  task automatic t_wrap_jump();
    step(JMP, 11'h7FF, 5'b11000);
    chk("R3 jump top", 32'(pc), 32'h1FFF);
    chk("R5 flush after jump", 32'(flush), 1);
    step(SEQ);
    chk("R2 wrap", 32'(pc), 0);
    chk("R5 flush single", 32'(flush), 0);
    step(JMP, 11'h123, 5'b01111);
    chk("R3 page low bits ignored", 32'(pc), 32'h0923);
    step(SEQ);
    chk("R3 after flush", 32'(pc), 32'h0924);
  endtask

  task automatic t_flush_ignore();
    step(JMP, 11'h200, 5'b00000);
    chk("R5 jump", 32'(pc), 32'h0200);
    step(JMP, 11'h555, 5'b11000);
    chk("R5 jump ignored in flush", 32'(pc), 32'h0201);
    step(JMP, 11'h300, 5'b00000);
    op = RLW; lit = 8'h3C;
    #1;
    chk("R6 no write when flushed", 32'(w_wr), 0);
    step(RLW);
    chk("R5 retlw ignored in flush", 32'(pc), 32'h0301);
  endtask

  task automatic t_call_ret();
    logic [12:0] p = pc;
    step(CAL, 11'h050, 5'b10000);
    chk("R4 call target", 32'(pc), 32'h1050);
    chk("R5 flush after call", 32'(flush), 1);
    step(SEQ); step(SEQ);
    chk("R4 in callee", 32'(pc), 32'h1052);
    step(RET);
    chk("R4 return addr", 32'(pc), 32'(p));
    chk("R5 flush after return", 32'(flush), 1);
    step(SEQ);
    chk("R4 resume", 32'(pc), 32'(13'(p + 1)));
  endtask

  task automatic t_retlw();
    logic [12:0] p;
    do_call(11'h300, p);
    op = RLW; lit = 8'hA5;
    #1;
    chk("R6 w_wr", 32'(w_wr), 1);
    chk("R6 w_data", 32'(w_data), 32'hA5);
    step(RLW);
    chk("R6 pop", 32'(pc), 32'(p));
    chk("R5 flush after retlw", 32'(flush), 1);
    step(SEQ);
  endtask

  task automatic t_retfie();
    logic [12:0] p;
    chk("R7 gie low", 32'(gie), 0);
    do_call(11'h004, p);
    step(RFI);
    chk("R7 pop", 32'(pc), 32'(p));
    chk("R7 gie set", 32'(gie), 1);
    step(SEQ);
    gie_clr = 1'b1;
    step(SEQ);
    gie_clr = 1'b0;
    chk("R7 gie cleared", 32'(gie), 0);
  endtask

  task automatic t_skip();
    logic [12:0] p = pc;
    step(SKP, '0, '0, 1'b0);
    chk("R8 miss pc", 32'(pc), 32'(13'(p + 1)));
    chk("R8 miss no flush", 32'(flush), 0);
    step(SKP, '0, '0, 1'b1);
    chk("R8 hit pc", 32'(pc), 32'(13'(p + 2)));
    chk("R8 hit flush", 32'(flush), 1);
    step(SKP, '0, '0, 1'b1);
    chk("R8 skip in flush ignored", 32'(flush), 0);
    chk("R8 pc after cancel", 32'(pc), 32'(13'(p + 3)));
  endtask

  task automatic t_nest();
    logic [12:0] v [8];
    logic [12:0] got;
    for (int k = 0; k < 8; k++) do_call(11'(11'h100 + k * 16), v[k]);
    for (int k = 7; k >= 0; k--) begin
      do_ret(got);
      chk($sformatf("R9 level %0d", k), 32'(got), 32'(v[k]));
    end
  endtask

  task automatic t_overflow();
    logic [12:0] v [9];
    logic [12:0] got;
    for (int k = 0; k < 9; k++) do_call(11'(11'h400 + k * 8), v[k]);
    for (int k = 8; k >= 1; k--) begin
      do_ret(got);
      chk($sformatf("R10 pop %0d", k), 32'(got), 32'(v[k]));
    end
    do_ret(got);
    chk("R10 extra pop", 32'(got), 32'(v[8]));
  endtask

  initial begin
    rst_n = 1'b0; op = SEQ; imm = '0; page = '0; skip_hit = 1'b0;
    lit = '0; gie_clr = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_seq();
    t_wrap_jump();
    t_flush_ignore();
    t_call_ret();
    t_retlw();
    t_retfie();
    t_skip();
    t_nest();
    t_overflow();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule